// File: doc/BRIEF.md
# Configurable Two-Output Logic Cell

This block is one programmable logic cell of a reconfigurable fabric. A small truth-table store of eight words, each two bits wide, is indexed by three logic inputs, so the cell evaluates two independent three-input Boolean functions of the same inputs at once. Each of the two function results goes to its own D flip-flop on the common fabric clock. A per-output mode bit chooses what reaches that cell output: the raw table result, which is combinational, or the flip-flop value, which is registered.

The contents are loaded through a parallel configuration port. One write strobe stores a two-bit word at a three-bit word index. A second strobe loads the two mode bits. Both writes land on the rising clock edge. A synchronous reset clears only the two flip-flops. The table words and the mode bits survive reset, so a cell keeps its programmed function while the fabric's sequential state is cleared. To use only two inputs, tie the top input to 0. The cell then reads only the lower half of the table.

Top module: `clb_cell`

## Requirements
- R1: The word index is `4*lut_in[2] + 2*lut_in[1] + lut_in[0]`, so `lut_in[2]` is the most significant bit. Output bit k is bit k of the indexed word.
- R2: When `cfg_we` is high at a rising edge, `cfg_data` is stored at word `cfg_addr`, where `cfg_data[k]` goes to output k. The new value is visible from that edge on. All other words keep their values.
- R3: An output whose mode bit is 0 equals its table bit for the present `lut_in`, with no clock edge in between.
- R4: An output whose mode bit is 1 equals the table bit that was present at the last rising edge. It does not change between edges.
- R5: When `rst` is high at a rising edge, both flip-flops are cleared to 0, so every registered output reads 0 after that edge.
- R6: Reset does not change the table words or the mode bits.
- R7: The two mode bits act independently. Any of the four combinations gives one combinational and one registered output, both combinational, or both registered.
- R8: When `cfg_mode_we` is high at a rising edge, `cfg_mode` is loaded, where bit k is the mode of output k and 1 means registered. While `cfg_mode_we` is low, `cfg_mode` has no effect.
- R9: With `lut_in[2]` held at 0, the outputs depend only on words 0 to 3, whatever words 4 to 7 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset of the two flip-flops |
| cfg_we | input | 1 | Table word write strobe |
| cfg_addr | input | 3 | Table word index for a write |
| cfg_data | input | 2 | Table word value; bit k belongs to output k |
| cfg_mode_we | input | 1 | Mode register write strobe |
| cfg_mode | input | 2 | Mode bits; 1 = registered, 0 = combinational |
| lut_in | input | 3 | Logic inputs forming the word index |
| cell_out | output | 2 | Cell outputs |

## Verification
The hardest case to reach from the ports is a mixed-mode cell. There, one output has to show the word seen at the previous edge while the other already shows the word for the new input. The stimulus reaches it by sweeping every input value in a scrambled order under each of the four mode settings and for several truth tables. Each new input value is applied half a cycle after the edge that latched the previous one, so the expected pair combines the current and the previous word. Reset is pulsed with registered outputs holding ones, which shows at the ports both the flip-flop clearing and the programmed function coming back.

// File: rtl/clb_pkg.sv
package clb_pkg;
    localparam int CLB_SEL_W = 3;
    localparam int CLB_OUT_N = 2;
    localparam logic MODE_COMB = 1'b0;
    localparam logic MODE_REG  = 1'b1;
endpackage

// File: rtl/clb_truth_mem.sv
module clb_truth_mem #(
    parameter int SEL_W = clb_pkg::CLB_SEL_W,
    parameter int OUT_N = clb_pkg::CLB_OUT_N
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    input  logic [OUT_N-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_addr,
    output logic [OUT_N-1:0] rd_data
);
    localparam int DEPTH = 1 << SEL_W;

    logic [OUT_N-1:0] words [DEPTH];

    // Configuration storage: written on the edge, never cleared by reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Read side is purely combinational: the logic inputs select a word.
    assign rd_data = words[rd_addr];
endmodule

// File: rtl/clb_mode_reg.sv
module clb_mode_reg #(
    parameter int OUT_N = clb_pkg::CLB_OUT_N
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [OUT_N-1:0] wr_data,
    output logic [OUT_N-1:0] mode
);
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mode <= wr_data;
        end
    end
endmodule

// File: rtl/clb_out_stage.sv
module clb_out_stage #(
    parameter int OUT_N = clb_pkg::CLB_OUT_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OUT_N-1:0] lut_bits,
    input  logic [OUT_N-1:0] mode,
    output logic [OUT_N-1:0] out_bits
);
    logic [OUT_N-1:0] ff_q;

    for (genvar k = 0; k < OUT_N; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                ff_q[k] <= 1'b0;
            end else begin
                ff_q[k] <= lut_bits[k];
            end
        end

        always_comb begin
            unique case (mode[k])
                clb_pkg::MODE_REG:  out_bits[k] = ff_q[k];
                default:            out_bits[k] = lut_bits[k];
            endcase
        end
    end
endmodule

// File: rtl/clb_cell.sv
module clb_cell #(
    parameter int SEL_W = clb_pkg::CLB_SEL_W,
    parameter int OUT_N = clb_pkg::CLB_OUT_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_addr,
    input  logic [OUT_N-1:0] cfg_data,
    input  logic             cfg_mode_we,
    input  logic [OUT_N-1:0] cfg_mode,
    input  logic [SEL_W-1:0] lut_in,
    output logic [OUT_N-1:0] cell_out
);
    logic [OUT_N-1:0] lut_raw;
    logic [OUT_N-1:0] mode_r;

    clb_truth_mem #(.SEL_W(SEL_W), .OUT_N(OUT_N)) mem_i (
        .clk     (clk),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .rd_addr (lut_in),
        .rd_data (lut_raw)
    );

    clb_mode_reg #(.OUT_N(OUT_N)) mode_i (
        .clk     (clk),
        .wr_en   (cfg_mode_we),
        .wr_data (cfg_mode),
        .mode    (mode_r)
    );

    clb_out_stage #(.OUT_N(OUT_N)) out_i (
        .clk      (clk),
        .rst      (rst),
        .lut_bits (lut_raw),
        .mode     (mode_r),
        .out_bits (cell_out)
    );
endmodule

// File: rtl/clb_cell_chk.sv
module clb_cell_chk #(
    parameter int SEL_W = clb_pkg::CLB_SEL_W,
    parameter int OUT_N = clb_pkg::CLB_OUT_N
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [SEL_W-1:0] cfg_addr,
    input logic [OUT_N-1:0] cfg_data,
    input logic             cfg_mode_we,
    input logic [SEL_W-1:0] lut_in,
    input logic [OUT_N-1:0] lut_raw,
    input logic [OUT_N-1:0] mode_r,
    input logic [OUT_N-1:0] cell_out
);
    // Stored word becomes readable right after the write edge.
    assert_wr_visible_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && lut_in == cfg_addr) |=>
        ((lut_in != $past(lut_in)) || (lut_raw == $past(cfg_data))));

    // Mode register holds when its strobe is low.
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!rst && !cfg_mode_we) |=> $stable(mode_r));

    for (genvar k = 0; k < OUT_N; k++) begin : g_chk
        // Combinational lane mirrors the table bit.
        assert_comb_follow_R3: assert property (@(posedge clk) disable iff (rst)
            (mode_r[k] == 1'b0) |-> (cell_out[k] == lut_raw[k]));

        // Registered lane shows the table bit of the previous edge.
        assert_reg_delay_R4: assert property (@(posedge clk) disable iff (rst)
            !rst |=> ((mode_r[k] != 1'b1) || (cell_out[k] == $past(lut_raw[k]))));

        // Registered lane reads 0 on the first cycle after reset.
        assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
            ($past(rst) && mode_r[k] == 1'b1) |-> (cell_out[k] == 1'b0));
    end
endmodule

bind clb_cell clb_cell_chk #(.SEL_W(SEL_W), .OUT_N(OUT_N)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_data    (cfg_data),
    .cfg_mode_we (cfg_mode_we),
    .lut_in      (lut_in),
    .lut_raw     (lut_raw),
    .mode_r      (mode_r),
    .cell_out    (cell_out)
);

// File: tb/clb_cell_tb_top.sv
module clb_cell_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [2:0] cfg_addr;
    logic [1:0] cfg_data;
    logic       cfg_mode_we;
    logic [1:0] cfg_mode;
    logic [2:0] lut_in;
    logic [1:0] cell_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    clb_cell dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .cfg_mode_we(cfg_mode_we), .cfg_mode(cfg_mode),
        .lut_in(lut_in), .cell_out(cell_out)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [1:0] word_of(input logic [15:0] t, input int idx);
        return t[2*idx +: 2];
    endfunction

    task automatic wr_word(input int a, input logic [1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load(input logic [15:0] t);
        for (int i = 0; i < 8; i++) wr_word(i, word_of(t, i));
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_mode_we = 1'b1; cfg_mode = m;
        @(negedge clk);
        cfg_mode_we = 1'b0;
    endtask

    // R1 R3 R4 R7: scrambled sweep over all inputs for one mode setting.
    task automatic sweep(input logic [15:0] t, input logic [1:0] m);
        int prev;
        logic [1:0] exp;
        set_mode(m);
        lut_in = 3'd0;
        @(negedge clk);
        prev = 0;
        for (int s = 0; s < 8; s++) begin
            int v;
            v = (s * 5 + 3) % 8;
            @(negedge clk);
            lut_in = 3'(v);
            #2;
            for (int k = 0; k < 2; k++)
                exp[k] = m[k] ? word_of(t, prev)[k] : word_of(t, v)[k];
            check("R1 R3 R4 R7 sweep", cell_out, exp);
            prev = v;
        end
    endtask

    initial begin
        logic [15:0] tables [5];
        tables[0] = 16'h96E1; tables[1] = 16'h0F3C; tables[2] = 16'hFFFF;
        tables[3] = 16'h0000; tables[4] = 16'h5A27;

        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
        cfg_mode_we = 1'b0; cfg_mode = '0; lut_in = 3'd7;

        // Program while reset is held: all ones, both lanes registered.
        set_mode(2'b11);
        load(16'hFFFF);
        @(negedge clk); #2;
        check("R5 reset state", cell_out, 2'b00);

        rst = 1'b0;
        @(negedge clk); #2;
        check("R4 first capture", cell_out, 2'b11);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk); #2;
        check("R5 mid-run reset", cell_out, 2'b00);
        rst = 1'b0;
        @(negedge clk); #2;
        check("R6 config kept across reset", cell_out, 2'b11);
        set_mode(2'b00);
        #2;
        check("R6 table word kept", cell_out, 2'b11);

        for (int ti = 0; ti < 5; ti++) begin
            load(tables[ti]);
            for (int m = 0; m < 4; m++) sweep(tables[ti], 2'(m));
        end

        // R1: single marked word shows MSB ordering.
        load(16'h0100);
        set_mode(2'b00);
        @(negedge clk); lut_in = 3'd4; #2;
        check("R1 index 4 word", cell_out, 2'b01);
        @(negedge clk); lut_in = 3'd1; #2;
        check("R1 index 1 word", cell_out, 2'b00);

        // R2: one word rewritten, neighbour untouched.
        load(16'h96E1);
        wr_word(5, ~word_of(16'h96E1, 5));
        @(negedge clk); lut_in = 3'd5; #2;
        check("R2 rewritten word", cell_out, ~word_of(16'h96E1, 5));
        @(negedge clk); lut_in = 3'd4; #2;
        check("R2 neighbour word", cell_out, word_of(16'h96E1, 4));

        // R8: mode value without strobe has no effect.
        @(negedge clk);
        cfg_mode = 2'b11; cfg_mode_we = 1'b0; lut_in = 3'd2;
        @(negedge clk);
        lut_in = 3'd6; #2;
        check("R8 mode ignored without strobe", cell_out, word_of(16'h96E1, 6));
        @(negedge clk);
        lut_in = 3'd1; #2;
        check("R8 mode ignored without strobe", cell_out, word_of(16'h96E1, 1));

        // R9: upper half all ones, input 2 tied to 0.
        load(16'hFF4E);
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); lut_in = 3'(v); #2;
            check("R9 two-input use", cell_out, word_of(16'hFF4E, v));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule